// File: doc/BRIEF.md
# Shortest Stall-Time Thread Ranker

This block orders the hardware threads that share a memory request buffer. A batch scheduler pulses a start input when it has marked a new batch of requests. The ranker then works out how long each thread is likely to stall in that batch. Every thread's marked requests are counted per bank. The largest per-bank count is the thread's main stall estimate, and the total count is a secondary one. From these the ranker builds one ordering of all threads. The issue logic uses that ordering for every bank until the next batch.

The ranker copies the mark bits, the owner thread and target bank of each entry, and the per-thread priority levels at the clock edge that accepts the start pulse. It then walks the copied buffer one entry per cycle and updates a small array of counters. In the cycle after the walk ends, it orders the threads with a compare matrix. The new ranks are registered together with a one-cycle done pulse. Only counters, compares and a population count are used; there is no division.

Top module: `thread_rank_top`

## Requirements
- R1: After reset, thread t holds rank t, meaning `rank_o` reads 8'hE4 with the default parameters, and `rank_done_o` is low.
- R2: The buffer contents and priorities are taken at the clock edge where `batch_start_i` is high while the block is idle. Later changes to those inputs do not affect the batch in progress.
- R3: `rank_done_o` is high for exactly one cycle. It is sampled high NUM_ENTRIES+1 clock edges after the edge that accepted the start.
- R4: Only entries whose bit in `mark_i` is 1 are counted. Unmarked entries have no effect on any rank.
- R5: Among threads of equal priority, a thread with a smaller largest-per-bank marked count gets a smaller (better) rank.
- R6: When priority and the largest-per-bank count are equal, the thread with fewer marked entries in total gets the better rank.
- R7: The priority code compares ahead of both load measures, and code 0 is the most important. A thread with a smaller code always ranks ahead, whatever its load.
- R8: When priority and both load measures are all equal, the lower thread index gets the better rank.
- R9: Thread t's rank is in bits [RANK_W*t +: RANK_W] of `rank_o` (2 bits each by default), 0 being best. The ranks of all threads always form a permutation of 0..NUM_THREADS-1.
- R10: `rank_o` changes only in the cycle in which `rank_done_o` is high. A start pulse that arrives while a walk is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| batch_start_i | input | 1 | Pulse: a new batch has been marked |
| mark_i | input | NUM_ENTRIES | Per-entry batch mark bit |
| entry_tid_i | input | NUM_ENTRIES*TID_W | Owner thread of each entry; entry e in bits [TID_W*e +: TID_W] |
| entry_bank_i | input | NUM_ENTRIES*BANK_W | Target bank of each entry; entry e in bits [BANK_W*e +: BANK_W] |
| thread_prio_i | input | NUM_THREADS*PRIO_W | Priority code per thread, 0 most important |
| rank_o | output | NUM_THREADS*RANK_W | Per-thread rank, 0 best, held for the batch |
| rank_done_o | output | 1 | One-cycle pulse when new ranks are valid |

## Verification
The checker assumes that start pulses come from a source that knows the block accepts them only when idle. It also assumes that every thread and bank field names an existing thread or bank. The latency check follows acceptance on its own, counting a start as taken only when no walk is pending or when done is high. The bench changes inputs only on falling edges and holds them across the accepting edge. It sends one-cycle start pulses, and power-of-two defaults make every field value legal. One directed test deliberately sends a start while a walk is running, to exercise the ignore rule inside these assumptions.

// File: rtl/thread_rank_pkg.sv
package thread_rank_pkg;

  // Walk controller states
  typedef enum logic [1:0] {
    RK_IDLE = 2'd0,
    RK_SCAN = 2'd1,
    RK_SORT = 2'd2
  } rk_state_e;

endpackage

// File: rtl/thread_rank_scan.sv
// Captures the buffer on an accepted start, walks it one entry per cycle
// and accumulates marked requests per (thread, bank).
module thread_rank_scan
  import thread_rank_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int NUM_THREADS = 4,
  parameter int NUM_BANKS   = 4,
  parameter int PRIO_W      = 2,
  parameter int TID_W       = 2,
  parameter int BANK_W      = 2,
  parameter int CNT_W       = 5
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start_i,
  input  logic [NUM_ENTRIES-1:0]            mark_i,
  input  logic [NUM_ENTRIES*TID_W-1:0]      tid_i,
  input  logic [NUM_ENTRIES*BANK_W-1:0]     bank_i,
  input  logic [NUM_THREADS*PRIO_W-1:0]     prio_i,
  output logic [NUM_THREADS*NUM_BANKS*CNT_W-1:0] cnt_o,
  output logic [NUM_THREADS*PRIO_W-1:0]     prio_o,
  output logic                              sort_en_o
);

  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

  rk_state_e state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;
  logic             load_snap;
  logic             clr_cnt;
  logic             scan_act;

  logic [NUM_ENTRIES-1:0]        snap_mark_q;
  logic [NUM_ENTRIES*TID_W-1:0]  snap_tid_q;
  logic [NUM_ENTRIES*BANK_W-1:0] snap_bank_q;
  logic [NUM_THREADS*PRIO_W-1:0] snap_prio_q;

  logic              cur_mark;
  logic [TID_W-1:0]  cur_tid;
  logic [BANK_W-1:0] cur_bank;

  // Next-state logic
  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    idx_en    = 1'b0;
    load_snap = 1'b0;
    clr_cnt   = 1'b0;
    scan_act  = 1'b0;
    sort_en_o = 1'b0;
    case (state_q)
      RK_IDLE: begin
        if (start_i) begin
          load_snap = 1'b1;
          clr_cnt   = 1'b1;
          idx_d     = '0;
          idx_en    = 1'b1;
          state_d   = RK_SCAN;
        end
      end
      RK_SCAN: begin
        scan_act = 1'b1;
        if (idx_q == LAST_IDX) begin
          state_d = RK_SORT;
        end else begin
          idx_d  = idx_q + 1'b1;
          idx_en = 1'b1;
        end
      end
      RK_SORT: begin
        sort_en_o = 1'b1;
        state_d   = RK_IDLE;
      end
      default: state_d = RK_IDLE;
    endcase
  end

  // Controller registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RK_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (idx_en) idx_q <= idx_d;
    end
  end

  // Snapshot registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_mark_q <= '0;
      snap_tid_q  <= '0;
      snap_bank_q <= '0;
      snap_prio_q <= '0;
    end else if (load_snap) begin
      snap_mark_q <= mark_i;
      snap_tid_q  <= tid_i;
      snap_bank_q <= bank_i;
      snap_prio_q <= prio_i;
    end
  end

  assign cur_mark = snap_mark_q[idx_q];
  assign cur_tid  = snap_tid_q[idx_q*TID_W +: TID_W];
  assign cur_bank = snap_bank_q[idx_q*BANK_W +: BANK_W];
  assign prio_o   = snap_prio_q;

  // One counter per (thread, bank)
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam int K = t * NUM_BANKS + b;
      logic             hit;
      logic             cnt_en;
      logic [CNT_W-1:0] cnt_d, cnt_q;

      assign hit    = scan_act & cur_mark &
                      (cur_tid == TID_W'(t)) & (cur_bank == BANK_W'(b));
      assign cnt_en = clr_cnt | hit;

      always_comb begin
        if (clr_cnt) cnt_d = '0;
        else         cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_en) cnt_q <= cnt_d;
      end

      assign cnt_o[K*CNT_W +: CNT_W] = cnt_q;
    end
  end

endmodule

// File: rtl/thread_rank_metrics.sv
// Reduces the per-(thread, bank) counts to a largest-bank load and a total.
module thread_rank_metrics #(
  parameter int NUM_THREADS = 4,
  parameter int NUM_BANKS   = 4,
  parameter int CNT_W       = 5
) (
  input  logic [NUM_THREADS*NUM_BANKS*CNT_W-1:0] cnt_i,
  output logic [NUM_THREADS*CNT_W-1:0]           max_o,
  output logic [NUM_THREADS*CNT_W-1:0]           tot_o
);

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    logic [CNT_W-1:0] mx;
    logic [CNT_W-1:0] sm;
    logic [CNT_W-1:0] c;

    always_comb begin
      mx = '0;
      sm = '0;
      c  = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
        c  = cnt_i[(t*NUM_BANKS + b)*CNT_W +: CNT_W];
        sm = sm + c;
        if (c > mx) mx = c;
      end
    end

    assign max_o[t*CNT_W +: CNT_W] = mx;
    assign tot_o[t*CNT_W +: CNT_W] = sm;
  end

endmodule

// File: rtl/thread_rank_sort.sv
// Ranks threads with a pairwise compare matrix: each thread's rank is the
// number of threads whose key {priority, largest load, total, index} is smaller.
module thread_rank_sort #(
  parameter int NUM_THREADS = 4,
  parameter int PRIO_W      = 2,
  parameter int CNT_W       = 5,
  parameter int RANK_W      = 2
) (
  input  logic [NUM_THREADS*PRIO_W-1:0] prio_i,
  input  logic [NUM_THREADS*CNT_W-1:0]  max_i,
  input  logic [NUM_THREADS*CNT_W-1:0]  tot_i,
  output logic [NUM_THREADS*RANK_W-1:0] rank_o
);

  localparam int KEY_W = PRIO_W + 2 * CNT_W;

  logic [KEY_W-1:0] key [NUM_THREADS];

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_key
    assign key[t] = {prio_i[t*PRIO_W +: PRIO_W],
                     max_i[t*CNT_W +: CNT_W],
                     tot_i[t*CNT_W +: CNT_W]};
  end

  for (genvar i = 0; i < NUM_THREADS; i++) begin : g_row
    logic [NUM_THREADS-1:0] beaten;

    for (genvar j = 0; j < NUM_THREADS; j++) begin : g_col
      if (j == i) begin : g_self
        assign beaten[j] = 1'b0;
      end else if (j < i) begin : g_lower
        assign beaten[j] = (key[j] <= key[i]);
      end else begin : g_upper
        assign beaten[j] = (key[j] < key[i]);
      end
    end

    logic [RANK_W-1:0] r;
    always_comb begin
      r = '0;
      for (int j = 0; j < NUM_THREADS; j++) begin
        if (beaten[j]) r = r + 1'b1;
      end
    end

    assign rank_o[i*RANK_W +: RANK_W] = r;
  end

endmodule

// File: rtl/thread_rank_top.sv
module thread_rank_top #(
  parameter  int NUM_ENTRIES = 16,
  parameter  int NUM_THREADS = 4,
  parameter  int NUM_BANKS   = 4,
  parameter  int PRIO_W      = 2,
  localparam int TID_W       = $clog2(NUM_THREADS),
  localparam int BANK_W      = $clog2(NUM_BANKS),
  localparam int RANK_W      = $clog2(NUM_THREADS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          batch_start_i,
  input  logic [NUM_ENTRIES-1:0]        mark_i,
  input  logic [NUM_ENTRIES*TID_W-1:0]  entry_tid_i,
  input  logic [NUM_ENTRIES*BANK_W-1:0] entry_bank_i,
  input  logic [NUM_THREADS*PRIO_W-1:0] thread_prio_i,
  output logic [NUM_THREADS*RANK_W-1:0] rank_o,
  output logic                          rank_done_o
);

  localparam int CNT_W = $clog2(NUM_ENTRIES + 1);

  // Reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [NUM_THREADS*NUM_BANKS*CNT_W-1:0] cnt;
  logic [NUM_THREADS*PRIO_W-1:0]          prio_snap;
  logic [NUM_THREADS*CNT_W-1:0]           max_load;
  logic [NUM_THREADS*CNT_W-1:0]           tot_load;
  logic [NUM_THREADS*RANK_W-1:0]          rank_d, rank_q;
  logic                                   sort_en;
  logic                                   done_q;

  thread_rank_scan #(
    .NUM_ENTRIES(NUM_ENTRIES), .NUM_THREADS(NUM_THREADS),
    .NUM_BANKS(NUM_BANKS), .PRIO_W(PRIO_W), .TID_W(TID_W),
    .BANK_W(BANK_W), .CNT_W(CNT_W)
  ) u_scan (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start_i  (batch_start_i),
    .mark_i   (mark_i),
    .tid_i    (entry_tid_i),
    .bank_i   (entry_bank_i),
    .prio_i   (thread_prio_i),
    .cnt_o    (cnt),
    .prio_o   (prio_snap),
    .sort_en_o(sort_en)
  );

  thread_rank_metrics #(
    .NUM_THREADS(NUM_THREADS), .NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W)
  ) u_metrics (
    .cnt_i(cnt),
    .max_o(max_load),
    .tot_o(tot_load)
  );

  thread_rank_sort #(
    .NUM_THREADS(NUM_THREADS), .PRIO_W(PRIO_W),
    .CNT_W(CNT_W), .RANK_W(RANK_W)
  ) u_sort (
    .prio_i(prio_snap),
    .max_i (max_load),
    .tot_i (tot_load),
    .rank_o(rank_d)
  );

  // Rank and done registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      for (int t = 0; t < NUM_THREADS; t++) begin
        rank_q[t*RANK_W +: RANK_W] <= RANK_W'(t);
      end
      done_q <= 1'b0;
    end else begin
      if (sort_en) rank_q <= rank_d;
      done_q <= sort_en;
    end
  end

  assign rank_o      = rank_q;
  assign rank_done_o = done_q;

endmodule

// File: rtl/thread_rank_chk.sv
module thread_rank_chk #(
  parameter int NUM_ENTRIES = 16,
  parameter int NUM_THREADS = 4,
  parameter int RANK_W      = 2
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          start,
  input logic                          done,
  input logic [NUM_THREADS*RANK_W-1:0] rank
);

  localparam int CW = $clog2(NUM_ENTRIES + 3);
  localparam logic [CW-1:0] LAT = CW'(NUM_ENTRIES + 1);

  logic          busy_c;
  logic [CW-1:0] lat_c;
  logic [NUM_THREADS-1:0] seen;

  // Tracks acceptance on its own: idle, or the done cycle frees the walker
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_c <= 1'b0;
      lat_c  <= '0;
    end else if (start && (!busy_c || done)) begin
      busy_c <= 1'b1;
      lat_c  <= '0;
    end else if (done) begin
      busy_c <= 1'b0;
    end else if (busy_c && lat_c != {CW{1'b1}}) begin
      lat_c <= lat_c + 1'b1;
    end
  end

  always_comb begin
    seen = '0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      seen[rank[t*RANK_W +: RANK_W]] = 1'b1;
    end
  end

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy_c && lat_c == LAT));

  assert_rank_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rank) |-> done);

  assert_rank_perm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(seen) == NUM_THREADS);

endmodule

bind thread_rank_top thread_rank_chk #(
  .NUM_ENTRIES(NUM_ENTRIES), .NUM_THREADS(NUM_THREADS), .RANK_W(RANK_W)
) chk_i (
  .clk  (clk),
  .rst_n(rst_sync_n),
  .start(batch_start_i),
  .done (rank_done_o),
  .rank (rank_o)
);

// File: tb/thread_rank_top_tb_top.sv
module thread_rank_top_tb_top;

  localparam int NE = 16;
  localparam int NT = 4;

  typedef struct packed {
    logic [15:0] mark;
    logic [63:0] ent;   // nibble e = {tid[1:0], bank[1:0]} of entry e
    logic [7:0]  prio;
    logic [7:0]  exp;
  } vec_t;

  // R4/R5: unmarked T0 entries would otherwise make T0 worst
  // R6: equal largest loads separated by totals
  // R7: priority code ahead of load
  // R8: full tie -> thread index
  // R7/R8: priority only, no marks
  // R5/R6/R8: two equal threads ordered by index
  localparam vec_t VECS [6] = '{
    '{16'h03FF, 64'h1111_1132_144A_AADC, 8'h00, 8'h39},
    '{16'hFFFF, 64'hFEED_DCCB_A944_3210, 8'h00, 8'hC9},
    '{16'h03FF, 64'h1111_1132_144A_AADC, 8'h46, 8'h4B},
    '{16'h0000, 64'h0000_0000_0000_0000, 8'h00, 8'hE4},
    '{16'h0000, 64'h0000_0000_0000_0000, 8'h1B, 8'h1B},
    '{16'h003F, 64'h0000_0000_0099_00E6, 8'h00, 8'h72}
  };

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [NE-1:0] mark;
  logic [2*NE-1:0] tid;
  logic [2*NE-1:0] bank;
  logic [7:0]    prio;
  logic [7:0]    rank;
  logic          done;

  int n_chk;
  int n_bad;

  thread_rank_top dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .batch_start_i(start),
    .mark_i       (mark),
    .entry_tid_i  (tid),
    .entry_bank_i (bank),
    .thread_prio_i(prio),
    .rank_o       (rank),
    .rank_done_o  (done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic check(input logic ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic load_vec(input vec_t v);
    mark = v.mark;
    prio = v.prio;
    for (int e = 0; e < NE; e++) begin
      tid[2*e +: 2]  = v.ent[4*e+2 +: 2];
      bank[2*e +: 2] = v.ent[4*e +: 2];
    end
  endtask

  // Rank values distinct: bench-side permutation test
  function automatic logic is_perm(input logic [7:0] r);
    logic [3:0] s;
    s = '0;
    for (int t = 0; t < NT; t++) s[r[2*t +: 2]] = 1'b1;
    return (s == 4'hF);
  endfunction

  // Pulse start on one edge, return edges until done seen
  task automatic run_batch(input vec_t v, output int lat);
    @(negedge clk);
    load_vec(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    int lat;
    int extra;
    n_chk = 0;
    n_bad = 0;
    start = 1'b0;
    mark  = '0;
    tid   = '0;
    bank  = '0;
    prio  = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: reset state
    check(rank == 8'hE4, "R1 reset ranks", 64'(rank), 64'hE4);
    check(done == 1'b0,  "R1 reset done",  64'(done), 64'h0);

    // Table walk: ordering rules R4..R8, latency R3, encoding R9
    for (int k = 0; k < 6; k++) begin
      run_batch(VECS[k], lat);
      check(rank == VECS[k].exp, $sformatf("R5..R8 vector %0d ranks", k),
            64'(rank), 64'(VECS[k].exp));
      check(lat == NE + 1, $sformatf("R3 vector %0d latency", k),
            64'(lat), 64'(NE + 1));
      check(is_perm(rank), $sformatf("R9 vector %0d permutation", k),
            64'(rank), 64'(VECS[k].exp));
      @(negedge clk);
      check(done == 1'b0, $sformatf("R3 vector %0d single pulse", k),
            64'(done), 64'h0);
    end

    // R2/R10: inputs changed and a second start raised mid-walk
    @(negedge clk);
    load_vec(VECS[0]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    load_vec(VECS[1]);
    repeat (4) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 5;
    check(rank == 8'h72, "R10 ranks held during walk", 64'(rank), 64'h72);
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    check(rank == 8'h39, "R2 snapshot at accepted start", 64'(rank), 64'h39);
    check(lat == NE + 1, "R10 late start did not restart walk",
          64'(lat), 64'(NE + 1));
    extra = 0;
    for (int c = 0; c < 3 * NE; c++) begin
      @(negedge clk);
      if (done) extra++;
    end
    check(extra == 0, "R10 ignored start gives no done", 64'(extra), 64'h0);
    check(rank == 8'h39, "R10 ranks stable after batch", 64'(rank), 64'h39);

    // R1: reset mid-life returns identity
    rst_n = 1'b0;
    @(negedge clk);
    check(rank == 8'hE4 && done == 1'b0, "R1 reset again",
          64'(rank), 64'hE4);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    summary();
    $finish;
  end

endmodule